// File: doc/BRIEF.md
# Double-Buffered Input Handshake Port

This block is a parallel input port with two storage stages. A peripheral puts a word on the data pins and raises a strobe. The port takes the word into its first stage. The word moves to the second stage as soon as that stage is empty. A processor reads the second stage through a small register interface. A read of the low-byte register is destructive: it removes the oldest word. A read of the high-byte register only observes. The data-available status, the DMA request and the handshake output all advance on the low-byte read alone.

A handshake output tells the peripheral when it may send more data. It works in one of two forms:
- Interlocked: a level that is high while a stage is free.
- Pulsed: a fixed-length pulse each time software frees a stage.

An enable bit holds the handshake output low until software is ready. The port can run as one 8-bit port, or as a 16-bit port whose high byte is read first and whose low byte is read last. A strobe that arrives while both stages are full is dropped, and a sticky overrun flag records it.

The peripheral side follows its own strobe/handshake protocol, not valid/ready. Back-pressure reaches the peripheral only through the handshake output. A strobe that ignores that output is lost. It is never stalled.

Top module: `hsin_port`

## Requirements
- R1: After reset, the following are all low: handshake output, data-available, DMA request, overrun flag and control register (address 0 reads 0).
- R2: While the enable bit (control bit 0) is 0, the handshake output is low in every mode.
- R3: A rising strobe is seen through a two-flop synchronizer. The data pins are captured on the third clock edge after the strobe rises. If the port was empty, data-available rises one clock edge later.
- R4: The port holds up to two words in arrival order. A read of address 3 returns bits 7:0 of the oldest word and removes that word. A read of address 3 with no word available removes nothing.
- R5: A read of address 2 never removes a word. It returns bits 15:8 of the oldest word when wide mode (control bit 2) is 1, and 0 when wide mode is 0.
- R6: Reading address 1 returns the status register: bit 0 is data-available and bit 1 is overrun. The data-available output and the DMA request are high exactly while a word is available, and they fall only after an address-3 read.
- R7: In interlocked form (control bit 1 = 0) with the enable bit set, the handshake output is high exactly while fewer than two words are held.
- R8: In pulsed form (control bit 1 = 1), the handshake output goes high in the cycle after either trigger below and stays high for PULSE_LEN (4) cycles. A new trigger restarts the count. The triggers are:
  - each removing read of address 3;
  - the enable bit going from 0 to 1.
- R9: A captured strobe that finds two words held, with no removing read on the same edge, is dropped. It sets the overrun flag, which stays set until reset.
- R10: Writing address 0 sets the control bits from data bits 2:0: bit 0 enable, bit 1 pulsed form, bit 2 wide mode. Reading address 0 returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_i | input | 1 | Peripheral strobe, asynchronous, rising edge captures |
| pdata_i | input | 16 | Peripheral data |
| hs_o | output | 1 | Handshake back to the peripheral |
| cpu_we_i | input | 1 | Register write strobe |
| cpu_re_i | input | 1 | Register read strobe |
| cpu_addr_i | input | 2 | Register address |
| cpu_wdata_i | input | 8 | Register write data |
| cpu_rdata_o | output | 8 | Register read data for the current address |
| data_avail_o | output | 1 | A word is ready to read |
| dma_req_o | output | 1 | Request to an external controller to empty the port |
| overrun_o | output | 1 | Sticky dropped-strobe flag |

## Verification
The hardest case to reach is a strobe edge landing in the same clock edge as a removing read while both stages are full. In that case the old second-stage word leaves, the first-stage word moves up, and the new word must still be taken. Only a cycle-exact overlap of the synchronizer delay with the read reaches it. A pseudo-random phase lets strobes and low-byte reads fall on every cycle offset, so this case and its neighbours occur many times. A reference queue that ages each word by clock edges predicts which of these cases drops a word and which does not.

// File: rtl/hsin_pkg.sv
package hsin_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_HIGH = 2'd2,
    A_LOW  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic wide;
    logic pulsed;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/hsin_strobe_sync.sv
module hsin_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  // STAGES flops bring the strobe into the clock domain, one more marks the edge
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/hsin_buf2.sv
module hsin_buf2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic [W-1:0] cap_data_i,
  input  logic         pop_i,
  output logic         fin_valid_o,
  output logic [W-1:0] fin_data_o,
  output logic         full_o,
  output logic         overrun_o
);
  logic         ini_v, fin_v, ovr_q;
  logic [W-1:0] ini_d, fin_d;
  logic         move, accept;

  // The front stage refills whenever it is empty or is being emptied this cycle
  assign move   = ini_v & (~fin_v | pop_i);
  assign accept = cap_i & (~ini_v | move);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ini_v <= 1'b0;
      fin_v <= 1'b0;
      ini_d <= '0;
      fin_d <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (move) begin
        fin_d <= ini_d;
        fin_v <= 1'b1;
      end else if (pop_i) begin
        fin_v <= 1'b0;
      end
      if (accept) begin
        ini_d <= cap_data_i;
        ini_v <= 1'b1;
      end else if (move) begin
        ini_v <= 1'b0;
      end
      if (cap_i & ~accept) ovr_q <= 1'b1;
    end
  end

  assign fin_valid_o = fin_v;
  assign fin_data_o  = fin_d;
  assign full_o      = ini_v & fin_v;
  assign overrun_o   = ovr_q;
endmodule

// File: rtl/hsin_hs_ctrl.sv
module hsin_hs_ctrl #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic pulsed_i,
  input  logic full_i,
  input  logic pop_i,
  output logic hs_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             trig;

  assign trig = pop_i | (en_i & ~en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q <= en_i;
      if (!en_i)              cnt_q <= '0;
      else if (trig)          cnt_q <= CNT_W'(PULSE_LEN);
      else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign hs_o = en_i & (pulsed_i ? (cnt_q != '0) : ~full_i);
endmodule

// File: rtl/hsin_port.sv
module hsin_port
  import hsin_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stb_i,
  input  logic [2*BYTE_W-1:0] pdata_i,
  output logic                hs_o,
  input  logic                cpu_we_i,
  input  logic                cpu_re_i,
  input  logic [1:0]          cpu_addr_i,
  input  logic [BYTE_W-1:0]   cpu_wdata_i,
  output logic [BYTE_W-1:0]   cpu_rdata_o,
  output logic                data_avail_o,
  output logic                dma_req_o,
  output logic                overrun_o
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic              rise, pop, fin_v, full, ovr;
  logic [WORD_W-1:0] fin_d;
  logic              unused_wbits;

  assign unused_wbits = ^cpu_wdata_i[BYTE_W-1:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    ctrl_q <= '0;
    else if (cpu_we_i && cpu_addr_i == A_CTRL)     ctrl_q <= ctrl_t'(cpu_wdata_i[CTRL_W-1:0]);
  end

  // Only a read of the low byte retires a word
  assign pop = cpu_re_i & (cpu_addr_i == A_LOW) & fin_v;

  hsin_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(stb_i), .rise_o(rise)
  );

  hsin_buf2 #(.W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .cap_i(rise), .cap_data_i(pdata_i), .pop_i(pop),
    .fin_valid_o(fin_v), .fin_data_o(fin_d), .full_o(full), .overrun_o(ovr)
  );

  hsin_hs_ctrl #(.PULSE_LEN(PULSE_LEN)) u_hs (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl_q.en), .pulsed_i(ctrl_q.pulsed),
    .full_i(full), .pop_i(pop), .hs_o(hs_o)
  );

  always_comb begin
    cpu_rdata_o = '0;
    unique case (reg_addr_e'(cpu_addr_i))
      A_CTRL: cpu_rdata_o[CTRL_W-1:0] = ctrl_q;
      A_STAT: cpu_rdata_o[1:0]        = {ovr, fin_v};
      A_HIGH: cpu_rdata_o             = ctrl_q.wide ? fin_d[WORD_W-1:BYTE_W] : '0;
      A_LOW:  cpu_rdata_o             = fin_d[BYTE_W-1:0];
    endcase
  end

  assign data_avail_o = fin_v;
  assign dma_req_o    = fin_v;
  assign overrun_o    = ovr;
endmodule

// File: rtl/hsin_port_chk.sv
module hsin_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       pulsed,
  input logic       full,
  input logic       hs,
  input logic       avail,
  input logic       ovr,
  input logic       re,
  input logic [1:0] addr
);
  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !hs);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);

  // R6
  avail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && !(re && addr == 2'd3)) |=> avail);

  // R7
  ilk_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pulsed && full) |-> !hs);

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pulsed && $rose(hs)) |=> (!(en && pulsed) || hs));
endmodule

bind hsin_port hsin_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .pulsed(ctrl_q.pulsed),
  .full(full), .hs(hs_o), .avail(data_avail_o), .ovr(overrun_o),
  .re(cpu_re_i), .addr(cpu_addr_i)
);

// File: tb/test_hsin_port.sv
module test_hsin_port;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic [15:0] pdata = '0;
  logic we = 1'b0, re = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = '0;
  logic hs, avail, dma, ovr;
  logic [7:0] rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsin_port i_hsin_port (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .pdata_i(pdata), .hs_o(hs),
    .cpu_we_i(we), .cpu_re_i(re), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .data_avail_o(avail), .dma_req_o(dma), .overrun_o(ovr)
  );

  // Reference model: a queue of words, each aged in clock edges
  logic [15:0] mq[$];
  int          mage[$];
  int          m_cnt = 0;
  bit          m_en = 0, m_pulsed = 0, m_wide = 0, m_en_prev = 0, m_ovr = 0;
  bit          h1 = 0, h2 = 0, h3 = 0;

  function automatic bit m_vis();
    return (mq.size() > 0) && (mage[0] >= 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); mage.delete();
      m_cnt = 0; m_en = 0; m_pulsed = 0; m_wide = 0; m_en_prev = 0; m_ovr = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      bit popm, edg, trig;
      popm = re && addr == 2'd3 && m_vis();
      edg  = h2 && !h3;
      trig = popm || (m_en && !m_en_prev);
      if (!m_en) m_cnt = 0;
      else if (trig) m_cnt = PULSE;
      else if (m_cnt > 0) m_cnt--;
      m_en_prev = m_en;
      if (popm) begin void'(mq.pop_front()); void'(mage.pop_front()); end
      foreach (mage[i]) mage[i]++;
      if (edg) begin
        if (mq.size() < 2) begin mq.push_back(pdata); mage.push_back(0); end
        else m_ovr = 1;
      end
      h3 = h2; h2 = h1; h1 = stb;
      if (we && addr == 2'd0) {m_wide, m_pulsed, m_en} = wdata[2:0];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit v;
      v = m_vis();
      if (!m_en) chk("R2 handshake", 32'(hs), 0);
      else if (m_pulsed) chk("R8 pulsed handshake", 32'(hs), 32'(m_cnt > 0));
      else chk("R7 interlocked handshake", 32'(hs), 32'(mq.size() < 2));
      chk("R3 data available", 32'(avail), 32'(v));
      chk("R6 dma request", 32'(dma), 32'(v));
      chk("R9 overrun", 32'(ovr), 32'(m_ovr));
      case (addr)
        2'd0: chk("R10 control readback", 32'(rdata), {29'd0, m_wide, m_pulsed, m_en});
        2'd1: chk("R6 status", 32'(rdata), {30'd0, m_ovr, v});
        2'd2: if (v) chk("R5 high byte", 32'(rdata), m_wide ? 32'(mq[0][15:8]) : 0);
        default: if (v) chk("R4 low byte", 32'(rdata), 32'(mq[0][7:0]));
      endcase
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    @(negedge clk); we = 1; addr = 2'd0; wdata = v;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [1:0] a);
    @(negedge clk); addr = a; re = 1;
    @(negedge clk); re = 0;
  endtask

  task automatic strobe(logic [15:0] d);
    @(negedge clk); pdata = d; stb = 1;
    repeat (4) @(negedge clk);
    stb = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    // R1 reset state
    chk("R1 hs", 32'(hs), 0);
    chk("R1 avail", 32'(avail), 0);
    chk("R1 dma", 32'(dma), 0);
    chk("R1 overrun", 32'(ovr), 0);
    chk("R1 control", 32'(rdata), 0);

    strobe(16'h0011);          // R2: disabled, handshake stays low
    rd(2'd3);
    wr_ctrl(8'h01);            // R7 interlocked, narrow
    repeat (3) @(negedge clk);
    strobe(16'h12A5);          // R3 capture
    rd(2'd1);
    rd(2'd3);                  // R4 pop
    rd(2'd3);                  // R4 empty read removes nothing
    strobe(16'h3456);
    strobe(16'h789A);          // both stages full
    strobe(16'hDEAD);          // R9 dropped
    rd(2'd2);                  // R5 narrow returns 0, no pop
    rd(2'd1);
    rd(2'd3);
    rd(2'd3);
    wr_ctrl(8'h05);            // R5 wide mode
    strobe(16'hBEEF);
    rd(2'd2);
    rd(2'd2);
    rd(2'd3);
    wr_ctrl(8'h00);
    wr_ctrl(8'h03);            // R8 pulsed, enable rise pulse
    repeat (6) @(negedge clk);
    strobe(16'h4242);
    rd(2'd3);
    repeat (6) @(negedge clk);
    strobe(16'h1111);
    strobe(16'h2222);
    @(negedge clk); addr = 2'd3; re = 1;   // back-to-back pops retrigger
    @(negedge clk);
    @(negedge clk); re = 0;
    repeat (6) @(negedge clk);
    wr_ctrl(8'h02);            // R2 disabled in pulsed form
    strobe(16'h5555);
    rd(2'd3);

    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      stb   = lfsr[0] ^ lfsr[5];
      pdata = {lfsr[7:0], lfsr[15:8]} ^ 16'(i);
      re    = lfsr[2] & lfsr[9];
      addr  = lfsr[4:3];
      we    = (lfsr[11:6] == 6'h2A);
      wdata = {5'd0, lfsr[14:13], 1'b1};
    end
    @(negedge clk); re = 0; we = 0; stb = 0;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule